// File: doc/BRIEF.md
# Periodic Tick Timer

This block is a 24-bit down-counter that produces a regular heartbeat for a processor core. Software loads a reload value and enables the counter. Each time the count steps from one to zero, the block sets a sticky status flag. If requests are enabled, it also raises a one-cycle tick request to the exception logic. On the next count step the counter loads the reload value again, so the period is reload + 1 count steps.

The counter advances on every core clock cycle or on each rising edge of a slower reference clock. A control bit picks the source. The reference clock is synchronised into the core clock domain, and its rising edges act as count enables.

Four registers are reached through a simple register port: control/status, reload, current value and calibration. The port accepts a read or a write in every cycle and has no back-pressure. Read data is combinational in the cycle the read strobe is high. The calibration register only reflects input pins.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, reload and current registers read 0 and `tick_req` is low.
- R2: With control bit 0 (enable) and bit 2 (core clock source) set, each cycle loads the reload value when the count is 0 and otherwise decrements it by one. The period is reload + 1 cycles.
- R3: Control bit 16 becomes 1 after the count steps from 1 to 0. A read of the control register (index 0) returns the flag and clears it. Writing bit 16 has no effect.
- R4: A write of any value to the current register (index 2) sets the count to 0 and clears the bit-16 flag.
- R5: With control bit 1 set, `tick_req` is high for exactly one cycle, in the cycle the count first shows 0 after a 1-to-0 step. With bit 1 clear, `tick_req` stays low.
- R6: With a reload value of 0 the count stays at 0, and neither the flag nor a request is ever raised.
- R7: With control bit 2 clear, the counter steps only on synchronised rising edges of `ref_clk`. With no edges it does not move.
- R8: The calibration register (index 3) reads bit 31 = `cal_noref`, bit 30 = `cal_skew` and bits 23:0 = `cal_count`. Writes to it have no effect.
- R9: The reload register (index 1) holds 24 bits, and its bits 31:24 read 0. With control bit 0 clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the flag on a control read) |
| reg_idx | input | 2 | Register index: 0 control, 1 reload, 2 current, 3 calibration |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx` |
| ref_clk | input | 1 | Slow reference clock, asynchronous |
| cal_noref | input | 1 | Reference clock absent indication |
| cal_skew | input | 1 | Calibration value inexact indication |
| cal_count | input | 24 | 10 ms calibration count |
| tick_req | output | 1 | One-cycle tick request |

## Verification
The assertions assume that `reg_rd` and `reg_wr` are never high in the same cycle. They also assume that `ref_clk` stays at each level for several core cycles, so the synchroniser sees every edge. The stimulus drives each strobe alone for one cycle from the falling clock edge. It holds `ref_clk` high and low for four core cycles each. Expected counts, flags and pulse counts come from the reload + 1 period arithmetic. The bench reads them only through the register port and `tick_req`.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int CNT_W  = 24;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    REG_CTRL    = 2'd0,
    REG_RELOAD  = 2'd1,
    REG_CURRENT = 2'd2,
    REG_CALIB   = 2'd3
  } reg_idx_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_IRQ_BIT  = 1;
  localparam int CTRL_SRC_BIT  = 2;
  localparam int CTRL_FLAG_BIT = 16;
  localparam int CAL_NOREF_BIT = 31;
  localparam int CAL_SKEW_BIT  = 30;
endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q[0] <= async_in;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clear,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cur,
  output logic         hit
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
      hit <= 1'b0;
    end else begin
      hit <= 1'b0;
      if (clear) begin
        cur <= '0;
      end else if (run) begin
        if (cur == '0) begin
          cur <= reload;
        end else begin
          cur <= cur - ONE;
          hit <= (cur == ONE);
        end
      end
    end
  end
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_idx,
  input  logic [W-1:0]      reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              hit,
  input  logic [W-1:0]      cur,
  input  logic              cal_noref,
  input  logic              cal_skew,
  input  logic [W-1:0]      cal_count,
  output logic              en,
  output logic              irq_en,
  output logic              src_core,
  output logic [W-1:0]      reload,
  output logic              cur_wr
);
  logic flag_q;
  logic ctrl_wr, reload_wr, ctrl_rd;

  assign ctrl_wr   = reg_wr && (reg_idx == REG_CTRL);
  assign reload_wr = reg_wr && (reg_idx == REG_RELOAD);
  assign cur_wr    = reg_wr && (reg_idx == REG_CURRENT);
  assign ctrl_rd   = reg_rd && (reg_idx == REG_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= 1'b0;
      irq_en   <= 1'b0;
      src_core <= 1'b0;
      reload   <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en       <= reg_wdata[CTRL_EN_BIT];
        irq_en   <= reg_wdata[CTRL_IRQ_BIT];
        src_core <= reg_wdata[CTRL_SRC_BIT];
      end
      if (reload_wr) reload <= reg_wdata;
      // A zero step seen in the same cycle as a status read is kept.
      if (cur_wr)       flag_q <= 1'b0;
      else if (hit)     flag_q <= 1'b1;
      else if (ctrl_rd) flag_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_idx)
      REG_CTRL: begin
        reg_rdata[CTRL_EN_BIT]   = en;
        reg_rdata[CTRL_IRQ_BIT]  = irq_en;
        reg_rdata[CTRL_SRC_BIT]  = src_core;
        reg_rdata[CTRL_FLAG_BIT] = flag_q;
      end
      REG_RELOAD:  reg_rdata[W-1:0] = reload;
      REG_CURRENT: reg_rdata[W-1:0] = cur;
      default: begin
        reg_rdata[CAL_NOREF_BIT] = cal_noref;
        reg_rdata[CAL_SKEW_BIT]  = cal_skew;
        reg_rdata[W-1:0]         = cal_count;
      end
    endcase
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_BITS    = CNT_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [1:0]          reg_idx,
  input  logic [CNT_BITS-1:0] reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                ref_clk,
  input  logic                cal_noref,
  input  logic                cal_skew,
  input  logic [CNT_BITS-1:0] cal_count,
  output logic                tick_req
);
  logic                en, irq_en, src_core, cur_wr, hit, ref_rise, run;
  logic [CNT_BITS-1:0] reload, cur_val;

  ref_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(ref_clk), .rise(ref_rise)
  );

  assign run = en && (src_core || ref_rise);

  tick_counter #(.W(CNT_BITS)) cnt_i (
    .clk(clk), .rst_n(rst_n), .run(run), .clear(cur_wr),
    .reload(reload), .cur(cur_val), .hit(hit)
  );

  tick_regs #(.W(CNT_BITS)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hit(hit), .cur(cur_val), .cal_noref(cal_noref), .cal_skew(cal_skew),
    .cal_count(cal_count), .en(en), .irq_en(irq_en), .src_core(src_core),
    .reload(reload), .cur_wr(cur_wr)
  );

  assign tick_req = hit && irq_en;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         en,
  input logic         cur_wr,
  input logic [W-1:0] cur_val,
  input logic         tick_req
);
  assert_req_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_req |=> !tick_req);

  assert_req_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_req |-> (cur_val == '0));

  assert_zero_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_val == '0) |=> !tick_req);

  assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cur_wr && (cur_val != '0)) |=> (cur_val == $past(cur_val) - W'(1)));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_wr |=> (cur_val == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cur_wr) |=> $stable(cur_val));
endmodule

bind tick_timer tick_timer_chk #(.W(CNT_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .en(en), .cur_wr(cur_wr),
  .cur_val(cur_val), .tick_req(tick_req)
);

// File: tb/tick_timer_tb_top.sv
`timescale 1ns/1ps
module tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_idx = 2'd0;
  logic [23:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ref_clk = 1'b0;
  logic        cal_noref = 1'b0, cal_skew = 1'b0;
  logic [23:0] cal_count = '0;
  logic        tick_req;

  int total = 0, bad = 0, cyc = 0;

  always #4 clk = ~clk;

  tick_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ref_clk(ref_clk), .cal_noref(cal_noref), .cal_skew(cal_skew),
    .cal_count(cal_count), .tick_req(tick_req)
  );

  // reload, cycles after enable, expected count, expected flag
  localparam int unsigned VEC [8][4] = '{
    '{5, 1, 5, 0}, '{5, 4, 2, 0}, '{5, 6, 0, 1}, '{5, 7, 5, 1},
    '{3, 10, 2, 1}, '{1, 3, 1, 1}, '{0, 8, 0, 0}, '{100, 50, 51, 0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [23:0] d);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] v);
    reg_rd = 1'b1; reg_idx = idx;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic restart(input logic [23:0] rl, input logic [23:0] ctl);
    wr(2'd0, 24'd0);
    wr(2'd2, 24'd0);
    wr(2'd1, rl);
    wr(2'd0, ctl);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    int pulses;
    bit prev, dbl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check(v == 0, "R1 ctrl", v, 0);
    rd(2'd1, v); check(v == 0, "R1 reload", v, 0);
    rd(2'd2, v); check(v == 0, "R1 current", v, 0);
    check(tick_req == 1'b0, "R1 tick_req", {31'd0, tick_req}, 0);

    // R2 / R3 / R6 vector walk
    for (int i = 0; i < 8; i++) begin
      restart(VEC[i][0][23:0], 24'h5);
      repeat (VEC[i][1]) @(negedge clk);
      rd(2'd2, v); check(v == VEC[i][2], "R2 count vector", v, VEC[i][2]);
      rd(2'd0, v); check(v[16] == VEC[i][3][0], "R3 flag vector", {31'd0, v[16]}, VEC[i][3]);
    end

    // R3 read-to-clear, R9 hold while disabled
    restart(24'd20, 24'h5);
    repeat (22) @(negedge clk);
    wr(2'd0, 24'd0);
    rd(2'd0, v); check(v[16] == 1'b1, "R3 flag set", {31'd0, v[16]}, 1);
    rd(2'd0, v); check(v[16] == 1'b0, "R3 flag cleared by read", {31'd0, v[16]}, 0);
    rd(2'd2, v); check(v == 19, "R9 value at disable", v, 19);
    repeat (10) @(negedge clk);
    rd(2'd2, v); check(v == 19, "R9 held while disabled", v, 19);
    wr(2'd0, 24'h010000);
    rd(2'd0, v); check(v == 0, "R3 flag not writable", v, 0);

    // R4 current write clears count and flag
    wr(2'd0, 24'h5);
    repeat (25) @(negedge clk);
    wr(2'd0, 24'd0);
    wr(2'd2, 24'h123);
    rd(2'd2, v); check(v == 0, "R4 count zeroed", v, 0);
    rd(2'd0, v); check(v[16] == 1'b0, "R4 flag cleared", {31'd0, v[16]}, 0);

    // R5 request pulses, reload 4 -> zero at cycles 5, 10, 15
    restart(24'd4, 24'h7);
    pulses = 0; prev = 0; dbl = 0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (tick_req) pulses++;
      if (tick_req && prev) dbl = 1;
      prev = tick_req;
    end
    check(pulses == 3, "R5 pulse count", pulses, 3);
    check(!dbl, "R5 single-cycle pulse", {31'd0, dbl}, 0);
    restart(24'd4, 24'h5);
    pulses = 0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (tick_req) pulses++;
    end
    check(pulses == 0, "R5 no pulse when masked", pulses, 0);
    rd(2'd0, v); check(v[16] == 1'b1, "R5 flag still set when masked", {31'd0, v[16]}, 1);

    // R6 reload zero with requests enabled
    restart(24'd0, 24'h7);
    pulses = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (tick_req) pulses++;
    end
    check(pulses == 0, "R6 no request", pulses, 0);
    rd(2'd2, v); check(v == 0, "R6 count stays zero", v, 0);
    rd(2'd0, v); check(v == 32'h7, "R6 no flag", v, 32'h7);

    // R7 reference clock source
    restart(24'd3, 24'h1);
    repeat (20) @(negedge clk);
    rd(2'd2, v); check(v == 0, "R7 idle without edges", v, 0);
    for (int k = 0; k < 3; k++) begin
      ref_clk = 1'b1; repeat (4) @(negedge clk);
      ref_clk = 1'b0; repeat (4) @(negedge clk);
    end
    rd(2'd2, v); check(v == 1, "R7 three edges", v, 1);

    // R8 calibration pins, read-only
    cal_noref = 1'b1; cal_skew = 1'b0; cal_count = 24'h0ABCDE;
    @(negedge clk);
    rd(2'd3, v); check(v == 32'h800ABCDE, "R8 calibration A", v, 32'h800ABCDE);
    cal_noref = 1'b0; cal_skew = 1'b1; cal_count = 24'h123456;
    wr(2'd3, 24'hFFFFFF);
    rd(2'd3, v); check(v == 32'h40123456, "R8 calibration B", v, 32'h40123456);

    // R9 reload width
    wr(2'd1, 24'hFFFFFF);
    rd(2'd1, v); check(v == 32'h00FFFFFF, "R9 reload readback", v, 32'h00FFFFFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule